// File: doc/BRIEF.md
# Deferred Dirty-Rectangle Update Queue

This block gathers screen regions that producers mark as needing a redraw and replays them later, on the display-refresh tick. Each region is a rectangle of four signed 32-bit coordinates (x, y, width, height) pushed through a valid/ready port. The rectangles are held in a block-RAM-friendly ring store. When the refresh strobe arrives, the queue drains onto a downstream valid/ready port in push order. It can emit one rectangle per cycle while the consumer stays ready. A single-cycle done pulse marks the end of every drain.

Each rectangle is range-checked against fixed maximum extents and against the current surface size as it leaves the queue. A rectangle that fails the check is not dropped. It is widened to the whole surface, (0, 0, surface width, surface height). Pushing into a full queue starts a drain on its own, and the pending rectangle is stored once the queue is empty. If the invalidate flag is high when a drain starts, every queued entry is thrown away and nothing is emitted.

Top module: `dirty_rect_queue`

## Requirements
- R1: After reset, out_valid and drain_done are low and push_ready is high whenever refresh is low.
- R2: The queue holds DEPTH (default 512) rectangles. A push is accepted while fewer than DEPTH are stored, and push_ready stays low while DEPTH are stored.
- R3: A refresh strobe while idle drains every stored rectangle onto the output port in push order, and the queue is empty afterwards.
- R4: A push offered while the queue is full starts a drain without a refresh. When the drain finishes, that push is accepted and becomes the only stored entry.
- R5: If invalidate is high in the cycle a drain starts, no rectangle is emitted, drain_done still pulses, and the queue is empty afterwards.
- R6: A rectangle is in range only if x, y, width and height are all non-negative, x and width are each at most MAX_W (2368), and y and height are each at most MAX_H (1770).
- R7: A rectangle is also out of range if x + width exceeds surf_w or y + height exceeds surf_h. Equality is in range.
- R8: An out-of-range rectangle is emitted as (0, 0, surf_w, surf_h). An in-range rectangle is emitted unchanged.
- R9: push_ready is low while a drain is in progress, including whenever out_valid is high, and also in any cycle where refresh is high.
- R10: drain_done is high for the cycle right after the last output handshake of a drain. For a drain with nothing to emit, it is high in the first or second cycle after the start.
- R11: While out_valid is high and out_ready is low, out_valid and all four output coordinates hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| surf_w | input | 32 | Current surface width, unsigned |
| surf_h | input | 32 | Current surface height, unsigned |
| invalidate | input | 1 | Discard queued entries at the next drain start |
| refresh | input | 1 | Display-refresh strobe; starts a drain when idle |
| push_valid | input | 1 | Producer offers a rectangle |
| push_ready | output | 1 | Queue accepts the offered rectangle |
| push_x | input | 32 | Pushed x, signed |
| push_y | input | 32 | Pushed y, signed |
| push_w | input | 32 | Pushed width, signed |
| push_h | input | 32 | Pushed height, signed |
| out_valid | output | 1 | Emitted rectangle is valid |
| out_ready | input | 1 | Downstream accepts the rectangle |
| out_x | output | 32 | Emitted x |
| out_y | output | 32 | Emitted y |
| out_w | output | 32 | Emitted width |
| out_h | output | 32 | Emitted height |
| drain_done | output | 1 | One-cycle pulse at the end of each drain |

## Verification
A refresh sampled at a clock edge moves the block into draining at that edge. The store read issues at the next edge, and the first rectangle is loaded into the output register one edge after that. So the earliest output is valid two cycles after the strobe. The bench does not depend on that latency. It compares each rectangle at the handshake where it is taken, sampling at the falling edge, against a model queue filled at push time. drain_done is checked to appear exactly one cycle after the last handshake. The check at the falling edge after the strobe, plus the wait that follows, covers a pulse one cycle after the strobe (invalidate) or two cycles after it (empty queue). Ready on the push side is combinational from state and refresh, so the bench reads it at the falling edge before the rising edge that completes the transfer.

// File: rtl/rq_pkg.sv
package rq_pkg;

  localparam int CW = 32;

  typedef logic signed [CW-1:0] coord_t;

  typedef struct packed {
    coord_t x;
    coord_t y;
    coord_t w;
    coord_t h;
  } rect_t;

  localparam int RECT_W = $bits(rect_t);

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } drain_state_t;

endpackage

// File: rtl/rect_store.sv
module rect_store #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 128,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Single write port, registered read port: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/rect_check.sv
module rect_check
  import rq_pkg::*;
#(
  parameter int MAX_W = 2368,
  parameter int MAX_H = 1770
) (
  input  rect_t         rect_in,
  input  logic [CW-1:0] sw,
  input  logic [CW-1:0] sh,
  output rect_t         rect_out,
  output logic          in_range
);

  localparam coord_t LIM_W = coord_t'(MAX_W);
  localparam coord_t LIM_H = coord_t'(MAX_H);

  logic signed [CW:0] x_end, y_end, sw_s, sh_s;
  logic               signs_ok, caps_ok, surf_ok;

  always_comb begin
    x_end = $signed({rect_in.x[CW-1], rect_in.x}) + $signed({rect_in.w[CW-1], rect_in.w});
    y_end = $signed({rect_in.y[CW-1], rect_in.y}) + $signed({rect_in.h[CW-1], rect_in.h});
    sw_s  = $signed({1'b0, sw});
    sh_s  = $signed({1'b0, sh});

    signs_ok = !rect_in.x[CW-1] && !rect_in.y[CW-1] &&
               !rect_in.w[CW-1] && !rect_in.h[CW-1];
    caps_ok  = (rect_in.x <= LIM_W) && (rect_in.w <= LIM_W) &&
               (rect_in.y <= LIM_H) && (rect_in.h <= LIM_H);
    surf_ok  = (x_end <= sw_s) && (y_end <= sh_s);
    in_range = signs_ok && caps_ok && surf_ok;

    if (in_range) begin
      rect_out = rect_in;
    end else begin
      rect_out.x = '0;
      rect_out.y = '0;
      rect_out.w = coord_t'(sw);
      rect_out.h = coord_t'(sh);
    end
  end

endmodule

// File: rtl/rq_ctrl.sv
module rq_ctrl
  import rq_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_valid,
  input  logic            refresh,
  input  logic            invalidate,
  input  logic            out_valid,
  input  logic            out_ready,
  output logic            push_ready,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic            rd_en,
  output logic [AW-1:0]   rd_addr,
  output logic            load,
  output logic            drain_done,
  output logic [CNTW-1:0] fill
);

  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);
  localparam logic [AW-1:0]   LAST_IDX = AW'(DEPTH - 1);

  drain_state_t    state;
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count, count_nx;
  logic            q_vld;
  logic            idle, full, start, out_free, finish;

  always_comb begin
    idle       = (state == ST_IDLE);
    full       = (count == FULL_CNT);
    push_ready = idle && !full && !refresh;
    wr_en      = push_valid && push_ready;
    start      = idle && (refresh || (push_valid && full));
    out_free   = !out_valid || out_ready;
    load       = q_vld && out_free;
    rd_en      = !idle && (count != '0) && (!q_vld || load);
    finish     = !idle && (count == '0) && !q_vld && out_free;
    count_nx   = count + CNTW'(wr_en) - CNTW'(rd_en);
  end

  assign wr_addr = wr_ptr;
  assign rd_addr = rd_ptr;
  assign fill    = count;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      q_vld      <= 1'b0;
      drain_done <= 1'b0;
    end else begin
      drain_done <= 1'b0;
      count      <= count_nx;
      if (wr_en) begin
        wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      end
      if (rd_en) begin
        rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      end
      if (rd_en) begin
        q_vld <= 1'b1;
      end else if (load) begin
        q_vld <= 1'b0;
      end

      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (invalidate) begin
              // No push can be accepted in a start cycle (refresh or full
              // gates ready), so the write pointer is settled here.
              rd_ptr     <= wr_ptr;
              count      <= '0;
              drain_done <= 1'b1;
            end else begin
              state <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          if (finish) begin
            state      <= ST_IDLE;
            drain_done <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dirty_rect_queue.sv
module dirty_rect_queue
  import rq_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int MAX_W = 2368,
  parameter int MAX_H = 1770,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CW-1:0]        surf_w,
  input  logic [CW-1:0]        surf_h,
  input  logic                 invalidate,
  input  logic                 refresh,
  input  logic                 push_valid,
  output logic                 push_ready,
  input  logic signed [CW-1:0] push_x,
  input  logic signed [CW-1:0] push_y,
  input  logic signed [CW-1:0] push_w,
  input  logic signed [CW-1:0] push_h,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [CW-1:0] out_x,
  output logic signed [CW-1:0] out_y,
  output logic signed [CW-1:0] out_w,
  output logic signed [CW-1:0] out_h,
  output logic                 drain_done
);

  logic              wr_en, rd_en, load, rect_ok;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [CNTW-1:0]   fill_cnt;
  logic [RECT_W-1:0] rd_word;
  rect_t             wr_rect, rd_rect, fixed_rect, out_rect;

  assign wr_rect = '{x: push_x, y: push_y, w: push_w, h: push_h};
  assign rd_rect = rect_t'(rd_word);

  rq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .refresh    (refresh),
    .invalidate (invalidate),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .push_ready (push_ready),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .load       (load),
    .drain_done (drain_done),
    .fill       (fill_cnt)
  );

  rect_store #(.DEPTH(DEPTH), .WIDTH(RECT_W)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_rect),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  rect_check #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_check (
    .rect_in  (rd_rect),
    .sw       (surf_w),
    .sh       (surf_h),
    .rect_out (fixed_rect),
    .in_range (rect_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_rect  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_rect  <= fixed_rect;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_x = out_rect.x;
  assign out_y = out_rect.y;
  assign out_w = out_rect.w;
  assign out_h = out_rect.h;

endmodule

// File: rtl/rect_queue_chk.sv
module rect_queue_chk #(
  parameter int DEPTH = 512,
  parameter int CNTW  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              push_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [31:0]       out_x,
  input logic [31:0]       out_y,
  input logic [31:0]       out_w,
  input logic [31:0]       out_h,
  input logic              drain_done,
  input logic [CNTW-1:0]   fill
);

  // R2: occupancy never passes capacity
  a_r2_fill_bounded: assert property (@(posedge clk) disable iff (rst)
    fill <= CNTW'(DEPTH));

  // R3: the queue is empty when a drain reports completion
  a_r3_empty_at_done: assert property (@(posedge clk) disable iff (rst)
    drain_done |-> (fill == '0));

  // R9: no push can be taken while a rectangle is being presented
  a_r9_ready_low: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !push_ready);

  // R10: completion comes after the last rectangle has left
  a_r10_done_after_output: assert property (@(posedge clk) disable iff (rst)
    drain_done |-> !out_valid);

  // R11: a stalled output holds
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)
                                   && $stable(out_w) && $stable(out_h)));

endmodule

bind dirty_rect_queue rect_queue_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) u_rq_chk (
  .clk        (clk),
  .rst        (rst),
  .push_ready (push_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_x      (out_x),
  .out_y      (out_y),
  .out_w      (out_w),
  .out_h      (out_h),
  .drain_done (drain_done),
  .fill       (fill_cnt)
);

// File: tb/tb_dirty_rect_queue.sv
module tb_dirty_rect_queue;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 512;
  localparam int MAX_W      = 2368;
  localparam int MAX_H      = 1770;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] surf_w = 32'd800, surf_h = 32'd600;
  logic        invalidate = 1'b0, refresh = 1'b0, push_valid = 1'b0;
  logic        push_ready;
  logic signed [31:0] push_x = '0, push_y = '0, push_w = '0, push_h = '0;
  logic        out_valid, out_ready = 1'b1;
  logic signed [31:0] out_x, out_y, out_w, out_h;
  logic        drain_done;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_hs = -10, hs_total = 0, model_cnt = 0;
  bit ready_rand = 1'b0;
  logic [127:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dirty_rect_queue #(.DEPTH(DEPTH), .MAX_W(MAX_W), .MAX_H(MAX_H)) dut (
    .clk(clk), .rst(rst), .surf_w(surf_w), .surf_h(surf_h),
    .invalidate(invalidate), .refresh(refresh),
    .push_valid(push_valid), .push_ready(push_ready),
    .push_x(push_x), .push_y(push_y), .push_w(push_w), .push_h(push_h),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_w(out_w), .out_h(out_h),
    .drain_done(drain_done)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] expect_rect(int x, int y, int w, int h, int sw, int sh);
    bit ok;
    ok = x >= 0 && y >= 0 && w >= 0 && h >= 0 &&
         x <= MAX_W && w <= MAX_W && y <= MAX_H && h <= MAX_H &&
         (longint'(x) + w) <= sw && (longint'(y) + h) <= sh;
    return ok ? {x, y, w, h} : {32'd0, 32'd0, sw, sh};
  endfunction

  // out_ready changes just after the rising edge; monitor samples at the falling edge
  always @(posedge clk) begin
    #1 out_ready = ready_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (out_valid) chk(!push_ready, "R9 ready low while out_valid", {127'd0, push_ready}, 128'd0);
      if (drain_done && last_hs >= 0)
        chk(cyc == last_hs + 1, "R10 done timing", cyc, last_hs + 1);
      if (drain_done) last_hs = -10;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected rectangle", {out_x, out_y, out_w, out_h}, 128'd0);
        end else begin
          logic [127:0] e;
          e = exp_q.pop_front();
          chk({out_x, out_y, out_w, out_h} == e, "R3 R8 emitted rectangle",
              {out_x, out_y, out_w, out_h}, e);
        end
        last_hs = cyc;
        hs_total++;
      end
    end
  end

  task automatic push(input int x, input int y, input int w, input int h);
    @(negedge clk);
    if (model_cnt == DEPTH) begin
      chk(!push_ready, "R4 ready low when full", {127'd0, push_ready}, 128'd0);
      model_cnt = 0;
    end
    exp_q.push_back(expect_rect(x, y, w, h, int'(surf_w), int'(surf_h)));
    model_cnt++;
    push_x = x; push_y = y; push_w = w; push_h = h;
    push_valid = 1'b1;
    while (!push_ready) @(negedge clk);
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    @(negedge clk);
    refresh = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
    while (!drain_done) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    model_cnt = 0;
  endtask

  task automatic rand_push(input int sw, input int sh);
    int x, y, w, h;
    x = $urandom_range(0, sw); y = $urandom_range(0, sh);
    w = $urandom_range(0, sw / 2); h = $urandom_range(0, sh / 2);
    case ($urandom_range(0, 7))
      0: x = -int'($urandom_range(1, 50));
      1: h = MAX_H + int'($urandom_range(1, 9));
      default: ;
    endcase
    push(x, y, w, h);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hs0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(push_ready && !out_valid && !drain_done, "R1 reset state",
        {125'd0, push_ready, out_valid, drain_done}, 128'd4);

    // R6 R7 R8 directed boundaries on an 800x600 surface
    push(700, 0, 100, 10);   // x+w == sw: in range (R7)
    push(700, 0, 101, 10);   // x+w > sw: widened (R7, R8)
    push(0, 590, 5, 11);     // y+h > sh (R7)
    push(-1, 0, 4, 4);       // negative x (R6)
    push(3, 3, -2, 4);       // negative width (R6)
    drain("R3 queue drained, directed 800x600");

    // R6 caps on a surface larger than the caps
    surf_w = 32'd5000; surf_h = 32'd5000;
    push(2368, 0, 0, 0);     // x at cap: in range
    push(0, 0, 2369, 1);     // width over cap (R6)
    push(0, 1770, 0, 1770);  // y and h at cap: in range
    push(0, 1771, 0, 0);     // y over cap (R6)
    push(0, 0, 1, 1771);     // h over cap (R6)
    drain("R3 queue drained, cap corners");

    // R10 empty drain still pulses done
    drain("R10 empty drain");

    // R5 invalidate at drain start discards everything
    surf_w = 32'd1024; surf_h = 32'd768;
    for (int i = 0; i < 5; i++) push(i, i, 10, 10);
    invalidate = 1'b1;
    exp_q.delete();
    hs0 = hs_total;
    drain("R5 queue empty after invalidate");
    invalidate = 1'b0;
    chk(hs_total == hs0, "R5 nothing emitted on invalidate", hs_total, hs0);
    drain("R5 no leftovers after invalidate");
    chk(hs_total == hs0, "R5 later drain emits nothing", hs_total, hs0);

    // Random rounds with downstream backpressure (R3 R8 R11)
    ready_rand = 1'b1;
    for (int r = 0; r < 8; r++) begin
      case (r % 3)
        0: begin surf_w = 32'd640;  surf_h = 32'd480;  end
        1: begin surf_w = 32'd2368; surf_h = 32'd1770; end
        default: begin surf_w = 32'd1280; surf_h = 32'd1024; end
      endcase
      for (int k = 0; k < int'($urandom_range(1, 40)); k++)
        rand_push(int'(surf_w), int'(surf_h));
      drain("R3 queue drained, random round");
    end
    ready_rand = 1'b0;

    // R2 fill to capacity, R4 forced drain on the next push
    surf_w = 32'd2000; surf_h = 32'd1500;
    for (int i = 0; i < DEPTH; i++) push(i % 1000, i % 700, 3, 2);
    @(negedge clk);
    chk(!push_ready, "R2 ready low at capacity", {127'd0, push_ready}, 128'd0);
    hs0 = hs_total;
    push(11, 22, 33, 44);
    chk(hs_total == hs0 + DEPTH, "R4 forced drain emitted all", hs_total, hs0 + DEPTH);
    chk(exp_q.size() == 1, "R4 new entry kept after forced drain", exp_q.size(), 1);
    drain("R4 stored entry emitted by next drain");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule